// File: doc/BRIEF.md
# Per-Stream Time-Window Ingress Policer

This block decides, frame by frame, whether a received frame belongs to a policed stream and, if so, whether it arrived inside that stream's reception window. A stream entry holds a key (destination MAC with VLAN ID and priority, or destination MAC alone), the set of ingress ports that share the entry, a base time, an open length and a close length. Open and close lengths together form one cycle that repeats from the base time. A frame that arrives while its stream's gate is closed is discarded, as is a policed frame with no destination port or a length above the stream's limit.

Software fills the table through a write port. A write that would create a second valid entry with the same key is refused. For every frame presented on the arrival port, a verdict appears two clock cycles later: pass or drop, whether a stream matched, and which entry matched. Frames that match no entry pass unchanged. Each entry has one drop counter that merges all three drop causes. A read port returns a counter's value and clears it.

Top module: `stream_gate_policer`

## Requirements
- R1: After reset the table holds no valid entry, every drop counter reads 0 and `res_valid` is low.
- R2: A frame presented with `frm_valid` high gives `res_valid` high exactly two cycles later. A frame that matches no valid entry gets `res_pass`=1, `res_drop`=0 and `res_hit`=0.
- R3: A full-key entry (`cfg_mac_only`=0) matches when MAC, VID and PCP are all equal and bit `frm_port` of the entry's port set is 1. A MAC-only entry (`cfg_mac_only`=1) ignores VID and PCP. An entry's port set may list several ingress ports, and one schedule then governs all of them.
- R4: When several entries match, any full-key entry is chosen over MAC-only entries. Among entries of the same kind, the lowest index wins. `res_idx` reports the chosen entry.
- R5: For a matched frame, the phase is (ts - base) mod (open + close). The gate is open when the phase is below the open length, and the frame then passes if R7 and R8 also allow it.
- R6: A matched frame drops when the phase is greater than or equal to the open length (a phase equal to the open length drops). It also drops when ts < base, or when open + close = 0.
- R7: A matched frame whose destination mask `frm_dmask` is all zero is dropped.
- R8: A matched frame whose length exceeds the entry's maximum is dropped. A length equal to the maximum is allowed.
- R9: Every dropped frame adds one to the chosen entry's drop counter. A read (`rd_en`) returns the value one cycle later with `rd_valid` and clears the counter. If a read and an increment of the same counter fall in the same cycle, the read returns the old value and the counter holds 1.
- R10: With saturation enabled, a drop counter stops at 2^CNT_W - 1 and does not wrap.
- R11: Every write gives `cfg_ack` one cycle later. A valid write whose key mode and key equal those of another valid entry (a different index) raises `cfg_reject` and leaves the table unchanged. A full key and a MAC-only key of the same MAC are not duplicates.
- R12: Writing an entry with `cfg_valid`=0 removes it. Frames that only it matched then pass as misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | IDX_W | Entry index to write |
| cfg_valid | input | 1 | 1 installs the entry, 0 removes it |
| cfg_mac_only | input | 1 | 1: key is MAC only; 0: MAC, VID and PCP |
| cfg_mac | input | 48 | Destination MAC of the key |
| cfg_vid | input | 12 | VLAN ID of the key |
| cfg_pcp | input | 3 | Priority code of the key |
| cfg_ports | input | N_PORTS | Ingress ports that share the entry |
| cfg_base | input | TS_W | Schedule start time |
| cfg_open | input | TS_W | Open length per cycle |
| cfg_close | input | TS_W | Close length per cycle |
| cfg_maxlen | input | LEN_W | Largest allowed frame length |
| cfg_ack | output | 1 | Write completed, one cycle after `cfg_we` |
| cfg_reject | output | 1 | Write refused as duplicate key |
| frm_valid | input | 1 | Frame arrival strobe |
| frm_mac | input | 48 | Frame destination MAC |
| frm_vid | input | 12 | Frame VLAN ID |
| frm_pcp | input | 3 | Frame priority code |
| frm_port | input | PORT_W | Ingress port number |
| frm_len | input | LEN_W | Frame length |
| frm_dmask | input | N_PORTS | Destination port set |
| frm_ts | input | TS_W | Arrival timestamp |
| res_valid | output | 1 | Verdict valid |
| res_pass | output | 1 | Frame admitted |
| res_drop | output | 1 | Frame discarded |
| res_hit | output | 1 | Frame matched an entry |
| res_idx | output | IDX_W | Matched entry |
| rd_en | input | 1 | Counter read strobe |
| rd_idx | input | IDX_W | Counter to read |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | CNT_W | Counter value before clear |

## Verification
Frames from one stream are placed at phases inside the window, at its last open unit, exactly on the open/close edge and before the base time. These cases separate a correct modulo-and-compare from off-by-one and sign errors. A single key is sent from ports inside and outside a shared entry's port set, and with VID values that do and do not match. This shows the choice between full-key and MAC-only entries and shows priority. Empty destination sets and lengths at and just above the limit isolate the other two drop causes. Counter reads after bursts, after saturation and in the same cycle as an increment show that one counter merges all causes and that clear-on-read behaves correctly.

// File: rtl/sgp_pkg.sv
package sgp_pkg;
   localparam int MAC_W = 48;
   localparam int VID_W = 12;
   localparam int PCP_W = 3;

   typedef struct packed {
      logic [MAC_W-1:0] mac;
      logic [VID_W-1:0] vid;
      logic [PCP_W-1:0] pcp;
   } flow_key_t;

   typedef enum logic {
      KEY_FULL = 1'b0,
      KEY_MAC  = 1'b1
   } key_mode_e;
endpackage

// File: rtl/sgp_stream_cam.sv
module sgp_stream_cam
   import sgp_pkg::*;
#(
   parameter int N_ENTRIES = 8,
   parameter int N_PORTS   = 8,
   parameter int TS_W      = 32,
   parameter int LEN_W     = 14,
   localparam int IDX_W    = $clog2(N_ENTRIES),
   localparam int PORT_W   = $clog2(N_PORTS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic               wr_valid,
   input  key_mode_e          wr_mode,
   input  flow_key_t          wr_key,
   input  logic [N_PORTS-1:0] wr_ports,
   input  logic [TS_W-1:0]    wr_base,
   input  logic [TS_W-1:0]    wr_open,
   input  logic [TS_W-1:0]    wr_close,
   input  logic [LEN_W-1:0]   wr_maxlen,
   output logic               wr_ack,
   output logic               wr_reject,
   input  flow_key_t          lk_key,
   input  logic [PORT_W-1:0]  lk_port,
   output logic               lk_hit,
   output logic [IDX_W-1:0]   lk_idx,
   output logic [TS_W-1:0]    lk_base,
   output logic [TS_W-1:0]    lk_open,
   output logic [TS_W-1:0]    lk_close,
   output logic [LEN_W-1:0]   lk_maxlen
);
   logic               ent_valid  [N_ENTRIES];
   key_mode_e          ent_mode   [N_ENTRIES];
   flow_key_t          ent_key    [N_ENTRIES];
   logic [N_PORTS-1:0] ent_ports  [N_ENTRIES];
   logic [TS_W-1:0]    ent_base   [N_ENTRIES];
   logic [TS_W-1:0]    ent_open   [N_ENTRIES];
   logic [TS_W-1:0]    ent_close  [N_ENTRIES];
   logic [LEN_W-1:0]   ent_maxlen [N_ENTRIES];

   logic [N_ENTRIES-1:0] hit_full;
   logic [N_ENTRIES-1:0] hit_mac;
   logic [N_ENTRIES-1:0] dup;
   logic                 refuse;

   assign refuse = wr_en && wr_valid && (|dup);

   for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
      logic mac_eq, tag_eq, port_ok, wmac_eq, wtag_eq;
      assign mac_eq  = (ent_key[i].mac == lk_key.mac);
      assign tag_eq  = (ent_key[i].vid == lk_key.vid) && (ent_key[i].pcp == lk_key.pcp);
      assign port_ok = ent_ports[i][lk_port];
      assign hit_full[i] = ent_valid[i] && (ent_mode[i] == KEY_FULL) && mac_eq && tag_eq && port_ok;
      assign hit_mac[i]  = ent_valid[i] && (ent_mode[i] == KEY_MAC) && mac_eq && port_ok;

      assign wmac_eq = (ent_key[i].mac == wr_key.mac);
      assign wtag_eq = (ent_key[i].vid == wr_key.vid) && (ent_key[i].pcp == wr_key.pcp);
      assign dup[i]  = ent_valid[i] && (wr_idx != IDX_W'(i)) && (ent_mode[i] == wr_mode)
                       && wmac_eq && ((wr_mode == KEY_MAC) || wtag_eq);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_valid[i]  <= 1'b0;
            ent_mode[i]   <= KEY_FULL;
            ent_key[i]    <= '0;
            ent_ports[i]  <= '0;
            ent_base[i]   <= '0;
            ent_open[i]   <= '0;
            ent_close[i]  <= '0;
            ent_maxlen[i] <= '0;
         end else if (wr_en && !refuse && (wr_idx == IDX_W'(i))) begin
            ent_valid[i]  <= wr_valid;
            ent_mode[i]   <= wr_mode;
            ent_key[i]    <= wr_key;
            ent_ports[i]  <= wr_ports;
            ent_base[i]   <= wr_base;
            ent_open[i]   <= wr_open;
            ent_close[i]  <= wr_close;
            ent_maxlen[i] <= wr_maxlen;
         end
      end
   end

   // Full-key entries outrank MAC-only entries; lowest index wins within a kind.
   always_comb begin
      lk_idx = '0;
      for (int j = N_ENTRIES - 1; j >= 0; j--) begin
         if (hit_mac[j]) lk_idx = IDX_W'(j);
      end
      if (|hit_full) begin
         for (int j = N_ENTRIES - 1; j >= 0; j--) begin
            if (hit_full[j]) lk_idx = IDX_W'(j);
         end
      end
      lk_hit = (|hit_full) || (|hit_mac);
   end

   assign lk_base   = ent_base[lk_idx];
   assign lk_open   = ent_open[lk_idx];
   assign lk_close  = ent_close[lk_idx];
   assign lk_maxlen = ent_maxlen[lk_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ack    <= 1'b0;
         wr_reject <= 1'b0;
      end else begin
         wr_ack    <= wr_en;
         wr_reject <= refuse;
      end
   end
endmodule

// File: rtl/sgp_gate_eval.sv
module sgp_gate_eval #(
   parameter int TS_W       = 32,
   parameter bit CYCLE_POW2 = 1'b0,
   localparam int CW        = TS_W + 1
) (
   input  logic [TS_W-1:0] ts,
   input  logic [TS_W-1:0] base,
   input  logic [TS_W-1:0] open_len,
   input  logic [TS_W-1:0] close_len,
   output logic            gate_open
);
   logic [TS_W-1:0] elapsed;
   logic [CW-1:0]   cyc;
   logic [CW-1:0]   phase;
   logic            early;

   assign elapsed = ts - base;
   assign early   = (ts < base);
   assign cyc     = {1'b0, open_len} + {1'b0, close_len};

   if (CYCLE_POW2) begin : g_mask
      // Cycle length is assumed to be a power of two: phase is a bit mask.
      assign phase = {1'b0, elapsed} & (cyc - CW'(1));
   end else begin : g_mod
      assign phase = (cyc == '0) ? '0 : ({1'b0, elapsed} % cyc);
   end

   assign gate_open = !early && (cyc != '0) && (phase < {1'b0, open_len});
endmodule

// File: rtl/sgp_drop_counters.sv
module sgp_drop_counters #(
   parameter int N_ENTRIES = 8,
   parameter int CNT_W     = 32,
   parameter bit SATURATE  = 1'b1,
   localparam int IDX_W    = $clog2(N_ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_en,
   input  logic [IDX_W-1:0] inc_idx,
   input  logic             rd_en,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic [CNT_W-1:0] rd_data
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt [N_ENTRIES];

   for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cnt
      logic bump, take;
      assign bump = inc_en && (inc_idx == IDX_W'(i));
      assign take = rd_en && (rd_idx == IDX_W'(i));

      if (SATURATE) begin : g_sat
         always_ff @(posedge clk) begin
            if (!rst_n)    cnt[i] <= '0;
            else if (take) cnt[i] <= bump ? CNT_W'(1) : '0;
            else if (bump && (cnt[i] != CNT_MAX)) cnt[i] <= cnt[i] + CNT_W'(1);
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n)    cnt[i] <= '0;
            else if (take) cnt[i] <= bump ? CNT_W'(1) : '0;
            else if (bump) cnt[i] <= cnt[i] + CNT_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_en;
         rd_data  <= rd_en ? cnt[rd_idx] : '0;
      end
   end
endmodule

// File: rtl/stream_gate_policer.sv
module stream_gate_policer
   import sgp_pkg::*;
#(
   parameter int N_ENTRIES  = 8,
   parameter int N_PORTS    = 8,
   parameter int TS_W       = 32,
   parameter int LEN_W      = 14,
   parameter int CNT_W      = 32,
   parameter bit SATURATE   = 1'b1,
   parameter bit CYCLE_POW2 = 1'b0,
   localparam int IDX_W     = $clog2(N_ENTRIES),
   localparam int PORT_W    = $clog2(N_PORTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [IDX_W-1:0]     cfg_idx,
   input  logic                 cfg_valid,
   input  logic                 cfg_mac_only,
   input  logic [MAC_W-1:0]     cfg_mac,
   input  logic [VID_W-1:0]     cfg_vid,
   input  logic [PCP_W-1:0]     cfg_pcp,
   input  logic [N_PORTS-1:0]   cfg_ports,
   input  logic [TS_W-1:0]      cfg_base,
   input  logic [TS_W-1:0]      cfg_open,
   input  logic [TS_W-1:0]      cfg_close,
   input  logic [LEN_W-1:0]     cfg_maxlen,
   output logic                 cfg_ack,
   output logic                 cfg_reject,
   input  logic                 frm_valid,
   input  logic [MAC_W-1:0]     frm_mac,
   input  logic [VID_W-1:0]     frm_vid,
   input  logic [PCP_W-1:0]     frm_pcp,
   input  logic [PORT_W-1:0]    frm_port,
   input  logic [LEN_W-1:0]     frm_len,
   input  logic [N_PORTS-1:0]   frm_dmask,
   input  logic [TS_W-1:0]      frm_ts,
   output logic                 res_valid,
   output logic                 res_pass,
   output logic                 res_drop,
   output logic                 res_hit,
   output logic [IDX_W-1:0]     res_idx,
   input  logic                 rd_en,
   input  logic [IDX_W-1:0]     rd_idx,
   output logic                 rd_valid,
   output logic [CNT_W-1:0]     rd_data
);
   if (N_ENTRIES < 2) begin : g_chk_ent
      $error("N_ENTRIES must be at least 2");
   end
   if (N_PORTS < 2) begin : g_chk_port
      $error("N_PORTS must be at least 2");
   end
   if (TS_W < 2 || LEN_W < 1 || CNT_W < 1) begin : g_chk_w
      $error("TS_W, LEN_W and CNT_W are too small");
   end

   flow_key_t wr_key, lk_key;
   key_mode_e wr_mode;
   assign wr_key  = '{mac: cfg_mac, vid: cfg_vid, pcp: cfg_pcp};
   assign lk_key  = '{mac: frm_mac, vid: frm_vid, pcp: frm_pcp};
   assign wr_mode = cfg_mac_only ? KEY_MAC : KEY_FULL;

   logic             lk_hit;
   logic [IDX_W-1:0] lk_idx;
   logic [TS_W-1:0]  lk_base, lk_open, lk_close;
   logic [LEN_W-1:0] lk_maxlen;

   sgp_stream_cam #(
      .N_ENTRIES(N_ENTRIES), .N_PORTS(N_PORTS), .TS_W(TS_W), .LEN_W(LEN_W)
   ) u_cam (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_valid(cfg_valid), .wr_mode(wr_mode),
      .wr_key(wr_key), .wr_ports(cfg_ports), .wr_base(cfg_base), .wr_open(cfg_open),
      .wr_close(cfg_close), .wr_maxlen(cfg_maxlen), .wr_ack(cfg_ack), .wr_reject(cfg_reject),
      .lk_key(lk_key), .lk_port(frm_port), .lk_hit(lk_hit), .lk_idx(lk_idx),
      .lk_base(lk_base), .lk_open(lk_open), .lk_close(lk_close), .lk_maxlen(lk_maxlen)
   );

   // Stage 1: lookup result and frame attributes.
   logic               s1_valid, s1_hit;
   logic [IDX_W-1:0]   s1_idx;
   logic [TS_W-1:0]    s1_ts, s1_base, s1_open, s1_close;
   logic [LEN_W-1:0]   s1_len, s1_maxlen;
   logic [N_PORTS-1:0] s1_dmask;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid  <= 1'b0;
         s1_hit    <= 1'b0;
         s1_idx    <= '0;
         s1_ts     <= '0;
         s1_base   <= '0;
         s1_open   <= '0;
         s1_close  <= '0;
         s1_len    <= '0;
         s1_maxlen <= '0;
         s1_dmask  <= '0;
      end else begin
         s1_valid  <= frm_valid;
         s1_hit    <= frm_valid && lk_hit;
         s1_idx    <= lk_idx;
         s1_ts     <= frm_ts;
         s1_base   <= lk_base;
         s1_open   <= lk_open;
         s1_close  <= lk_close;
         s1_len    <= frm_len;
         s1_maxlen <= lk_maxlen;
         s1_dmask  <= frm_dmask;
      end
   end

   logic gate_open;
   sgp_gate_eval #(.TS_W(TS_W), .CYCLE_POW2(CYCLE_POW2)) u_gate (
      .ts(s1_ts), .base(s1_base), .open_len(s1_open), .close_len(s1_close),
      .gate_open(gate_open)
   );

   logic bad_time, bad_dest, bad_len, drop_now;
   assign bad_time = !gate_open;
   assign bad_dest = (s1_dmask == '0);
   assign bad_len  = (s1_len > s1_maxlen);
   assign drop_now = s1_valid && s1_hit && (bad_time || bad_dest || bad_len);

   // Stage 2: verdict.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_pass  <= 1'b0;
         res_drop  <= 1'b0;
         res_hit   <= 1'b0;
         res_idx   <= '0;
      end else begin
         res_valid <= s1_valid;
         res_pass  <= s1_valid && !drop_now;
         res_drop  <= drop_now;
         res_hit   <= s1_valid && s1_hit;
         res_idx   <= s1_idx;
      end
   end

   sgp_drop_counters #(
      .N_ENTRIES(N_ENTRIES), .CNT_W(CNT_W), .SATURATE(SATURATE)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .inc_en(drop_now), .inc_idx(s1_idx),
      .rd_en(rd_en), .rd_idx(rd_idx),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );
endmodule

// File: rtl/stream_gate_policer_chk.sv
module stream_gate_policer_chk #(
   parameter int N_PORTS = 8,
   parameter int LEN_W   = 14
) (
   input logic               clk,
   input logic               rst_n,
   input logic               frm_valid,
   input logic               res_valid,
   input logic               res_pass,
   input logic               res_drop,
   input logic               res_hit,
   input logic               cfg_we,
   input logic               cfg_valid,
   input logic               cfg_ack,
   input logic               cfg_reject,
   input logic               rd_en,
   input logic               rd_valid,
   input logic               s1_valid,
   input logic               s1_hit,
   input logic [N_PORTS-1:0] s1_dmask,
   input logic [LEN_W-1:0]   s1_len,
   input logic [LEN_W-1:0]   s1_maxlen
);
   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |-> ##2 res_valid);

   p_miss_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_hit) |-> (res_pass && !res_drop));

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> (!res_pass && !res_drop && !res_hit));

   p_one_verdict_r5: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $onehot({res_pass, res_drop}));

   p_no_dest_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && s1_hit && (s1_dmask == '0)) |=> res_drop);

   p_too_long_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && s1_hit && (s1_len > s1_maxlen)) |=> res_drop);

   p_read_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);

   p_write_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> cfg_ack);

   p_reject_install_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_reject |-> (cfg_ack && $past(cfg_valid)));
endmodule

bind stream_gate_policer stream_gate_policer_chk #(.N_PORTS(N_PORTS), .LEN_W(LEN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid),
   .res_valid(res_valid), .res_pass(res_pass), .res_drop(res_drop), .res_hit(res_hit),
   .cfg_we(cfg_we), .cfg_valid(cfg_valid), .cfg_ack(cfg_ack), .cfg_reject(cfg_reject),
   .rd_en(rd_en), .rd_valid(rd_valid),
   .s1_valid(s1_valid), .s1_hit(s1_hit), .s1_dmask(s1_dmask),
   .s1_len(s1_len), .s1_maxlen(s1_maxlen)
);

// File: tb/tb_stream_gate_policer.sv
module tb_stream_gate_policer;
   localparam int NE = 8;
   localparam int NP = 8;
   localparam int TW = 32;
   localparam int LW = 14;
   localparam int CW = 4;
   localparam int CMAX = 15;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic            rst_n;
   logic            cfg_we, cfg_valid, cfg_mac_only;
   logic [2:0]      cfg_idx;
   logic [47:0]     cfg_mac;
   logic [11:0]     cfg_vid;
   logic [2:0]      cfg_pcp;
   logic [NP-1:0]   cfg_ports;
   logic [TW-1:0]   cfg_base, cfg_open, cfg_close;
   logic [LW-1:0]   cfg_maxlen;
   logic            cfg_ack, cfg_reject;
   logic            frm_valid;
   logic [47:0]     frm_mac;
   logic [11:0]     frm_vid;
   logic [2:0]      frm_pcp;
   logic [2:0]      frm_port;
   logic [LW-1:0]   frm_len;
   logic [NP-1:0]   frm_dmask;
   logic [TW-1:0]   frm_ts;
   logic            res_valid, res_pass, res_drop, res_hit;
   logic [2:0]      res_idx;
   logic            rd_en;
   logic [2:0]      rd_idx;
   logic            rd_valid;
   logic [CW-1:0]   rd_data;

   stream_gate_policer #(
      .N_ENTRIES(NE), .N_PORTS(NP), .TS_W(TW), .LEN_W(LW), .CNT_W(CW)
   ) dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid), .cfg_mac_only(cfg_mac_only),
      .cfg_mac(cfg_mac), .cfg_vid(cfg_vid), .cfg_pcp(cfg_pcp), .cfg_ports(cfg_ports),
      .cfg_base(cfg_base), .cfg_open(cfg_open), .cfg_close(cfg_close), .cfg_maxlen(cfg_maxlen),
      .cfg_ack(cfg_ack), .cfg_reject(cfg_reject),
      .frm_valid(frm_valid), .frm_mac(frm_mac), .frm_vid(frm_vid), .frm_pcp(frm_pcp),
      .frm_port(frm_port), .frm_len(frm_len), .frm_dmask(frm_dmask), .frm_ts(frm_ts),
      .res_valid(res_valid), .res_pass(res_pass), .res_drop(res_drop), .res_hit(res_hit),
      .res_idx(res_idx), .rd_en(rd_en), .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_data(rd_data)
   );

   int checks = 0;
   int fails  = 0;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Model of the table as written by the bench.
   bit     m_valid [NE];
   longint m_base  [NE];
   longint m_open  [NE];
   longint m_close [NE];
   int     m_max   [NE];
   int     exp_cnt [NE];

   typedef struct {
      bit    pass;
      bit    hit;
      int    idx;
      string tag;
   } exp_t;
   exp_t sb[$];

   function automatic bit gate_ok(longint ts, longint b, longint o, longint c);
      longint cyc;
      if (ts < b) return 1'b0;
      cyc = o + c;
      if (cyc == 0) return 1'b0;
      return ((ts - b) % cyc) < o;
   endfunction

   // Monitor: compare each verdict with the oldest expectation.
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R2 unexpected verdict", 1, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(res_pass === e.pass && res_drop === !e.pass, {e.tag, " pass"},
                  longint'(res_pass), longint'(e.pass));
            check(res_hit === e.hit && (!e.hit || res_idx == 3'(e.idx)), {e.tag, " hit/idx"},
                  longint'({res_hit, res_idx}), longint'({e.hit, 3'(e.idx)}));
         end
      end
   end

   task automatic write_entry(input int idx, input bit valid, input bit mac_only,
                              input logic [47:0] mac, input int vid, input int pcp,
                              input logic [NP-1:0] ports, input longint base,
                              input longint op, input longint cl, input int maxlen,
                              input bit exp_rej, input string tag);
      cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_valid = valid; cfg_mac_only = mac_only;
      cfg_mac = mac; cfg_vid = 12'(vid); cfg_pcp = 3'(pcp); cfg_ports = ports;
      cfg_base = TW'(base); cfg_open = TW'(op); cfg_close = TW'(cl); cfg_maxlen = LW'(maxlen);
      @(negedge clk);
      cfg_we = 1'b0;
      check(cfg_ack === 1'b1 && cfg_reject === exp_rej, tag,
            longint'({cfg_ack, cfg_reject}), longint'({1'b1, exp_rej}));
      if (!exp_rej) begin
         m_valid[idx] = valid; m_base[idx] = base; m_open[idx] = op;
         m_close[idx] = cl; m_max[idx] = maxlen;
      end
   endtask

   task automatic send(input logic [47:0] mac, input int vid, input int pcp, input int port,
                       input int len, input logic [NP-1:0] dmask, input longint ts,
                       input bit hit, input int idx, input string tag);
      exp_t e;
      e.hit = hit; e.idx = idx; e.tag = tag;
      if (!hit) e.pass = 1'b1;
      else e.pass = gate_ok(ts, m_base[idx], m_open[idx], m_close[idx])
                    && (dmask != '0) && (len <= m_max[idx]);
      if (hit && !e.pass && exp_cnt[idx] < CMAX) exp_cnt[idx]++;
      sb.push_back(e);
      frm_valid = 1'b1; frm_mac = mac; frm_vid = 12'(vid); frm_pcp = 3'(pcp);
      frm_port = 3'(port); frm_len = LW'(len); frm_dmask = dmask; frm_ts = TW'(ts);
      @(negedge clk);
      frm_valid = 1'b0;
   endtask

   task automatic flush();
      repeat (4) @(negedge clk);
   endtask

   task automatic read_cnt(input int idx, input string tag);
      rd_en = 1'b1; rd_idx = 3'(idx);
      @(negedge clk);
      rd_en = 1'b0;
      check(rd_valid === 1'b1 && rd_data == CW'(exp_cnt[idx]), tag,
            longint'(rd_data), longint'(exp_cnt[idx]));
      exp_cnt[idx] = 0;
   endtask

   localparam logic [47:0] MAC_A = 48'h42be_249b_7620;
   localparam logic [47:0] MAC_B = 48'h0200_0000_0b0b;
   localparam logic [47:0] MAC_C = 48'h0200_0000_0c0c;

   bit done = 1'b0;

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         check(1'b0, "watchdog expired", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NE; i++) begin
         m_valid[i] = 0; exp_cnt[i] = 0; m_base[i] = 0;
         m_open[i] = 0; m_close[i] = 0; m_max[i] = 0;
      end
      rst_n = 1'b0; cfg_we = 0; cfg_idx = 0; cfg_valid = 0; cfg_mac_only = 0;
      cfg_mac = 0; cfg_vid = 0; cfg_pcp = 0; cfg_ports = 0; cfg_base = 0;
      cfg_open = 0; cfg_close = 0; cfg_maxlen = 0;
      frm_valid = 0; frm_mac = 0; frm_vid = 0; frm_pcp = 0; frm_port = 0;
      frm_len = 0; frm_dmask = 0; frm_ts = 0; rd_en = 0; rd_idx = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: quiet outputs, zero counters, empty table.
      check(res_valid === 1'b0, "R1 res_valid after reset", longint'(res_valid), 0);
      read_cnt(0, "R1 counter zero after reset");
      send(MAC_A, 100, 0, 1, 64, 8'hff, 5000, 0, 0, "R1 empty table miss");
      flush();

      // Table: 0 full key A/100/0 on ports 1,2; 1 MAC-only A; 2 full key B/5/3 always open.
      write_entry(0, 1, 0, MAC_A, 100, 0, 8'b0000_0110, 1000, 600, 400, 1500, 0, "R11 write e0");
      write_entry(1, 1, 1, MAC_A, 0, 0, 8'hff, 0, 500, 500, 1500, 0, "R11 write e1");
      write_entry(2, 1, 0, MAC_B, 5, 3, 8'hff, 0, 1000, 0, 100, 0, "R11 write e2");

      send(MAC_C, 100, 0, 1, 64, 8'hff, 1100, 0, 0, "R2 unknown MAC miss");
      send(MAC_A, 100, 0, 1, 64, 8'hff, 1100, 1, 0, "R5 open phase 100");
      send(MAC_A, 100, 0, 2, 64, 8'hff, 2599, 1, 0, "R3 shared port phase 599");
      send(MAC_A, 100, 0, 1, 64, 8'hff, 1600, 1, 0, "R6 phase equals open");
      send(MAC_A, 100, 0, 2, 64, 8'hff, 999, 1, 0, "R6 before base");
      send(MAC_A, 100, 0, 3, 64, 8'hff, 200, 1, 1, "R3 port outside set falls to MAC-only");
      send(MAC_A, 100, 0, 1, 64, 8'hff, 3050, 1, 0, "R4 full key beats MAC-only");
      send(MAC_A, 7, 0, 1, 64, 8'hff, 700, 1, 1, "R3 MAC-only ignores VID closed");
      send(MAC_A, 9, 5, 4, 64, 8'hff, 1499, 1, 1, "R5 MAC-only open");
      send(MAC_B, 5, 3, 0, 64, 8'h00, 10, 1, 2, "R7 empty destination");
      send(MAC_B, 5, 3, 0, 100, 8'h01, 10, 1, 2, "R8 length at limit");
      send(MAC_B, 5, 3, 0, 101, 8'h01, 10, 1, 2, "R8 length over limit");
      send(MAC_B, 5, 2, 0, 64, 8'h01, 10, 0, 0, "R3 PCP mismatch miss");
      flush();

      // R9: merged counter, clear on read.
      read_cnt(0, "R9 entry0 drops");
      read_cnt(0, "R9 entry0 cleared");
      read_cnt(1, "R9 entry1 drops");
      read_cnt(2, "R9 entry2 merged causes");

      // R11: duplicate refused, other mode accepted, same index rewrite accepted.
      write_entry(3, 1, 0, MAC_B, 5, 3, 8'hff, 0, 10, 10, 100, 1, "R11 duplicate refused");
      send(MAC_B, 5, 3, 0, 64, 8'h01, 15, 1, 2, "R11 table unchanged");
      write_entry(3, 1, 1, MAC_B, 0, 0, 8'hff, 0, 0, 0, 100, 0, "R11 MAC-only same MAC accepted");
      send(MAC_B, 5, 3, 0, 64, 8'h01, 15, 1, 2, "R4 full key over MAC-only idx3");
      send(MAC_B, 6, 3, 0, 64, 8'h01, 15, 1, 3, "R6 zero-length cycle drops");
      write_entry(2, 1, 0, MAC_B, 5, 3, 8'hff, 0, 1000, 0, 100, 0, "R11 rewrite own index");
      flush();
      read_cnt(3, "R6 entry3 counter");

      // R12: removal.
      write_entry(3, 0, 1, MAC_B, 0, 0, 8'hff, 0, 0, 0, 100, 0, "R12 remove e3");
      write_entry(2, 0, 0, MAC_B, 5, 3, 8'hff, 0, 1000, 0, 100, 0, "R12 remove e2");
      send(MAC_B, 5, 3, 0, 64, 8'h00, 15, 0, 0, "R12 removed entry misses");
      flush();

      // R10: saturation.
      for (int k = 0; k < CMAX + 2; k++) begin
         send(MAC_A, 7, 0, 1, 64, 8'hff, 700, 1, 1, "R10 burst drop");
      end
      flush();
      read_cnt(1, "R10 saturated value");

      // R9: read and increment in the same cycle.
      send(MAC_A, 7, 0, 1, 64, 8'hff, 700, 1, 1, "R9 drop before read");
      rd_en = 1'b1; rd_idx = 3'd1;
      @(negedge clk);
      rd_en = 1'b0;
      check(rd_valid === 1'b1 && rd_data == '0, "R9 same-cycle read returns old value",
            longint'(rd_data), 0);
      flush();
      read_cnt(1, "R9 same-cycle increment kept");

      flush();
      check(sb.size() == 0, "R2 all verdicts received", longint'(sb.size()), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule